// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Unit

This block gathers every interrupt condition of a FIFO-mode UART and turns them into one read-only 8-bit identification byte. Six causes compete: receiver line errors, received data at or above the FIFO trigger, character timeout, transmitter holder empty, modem line changes, and a group of four extended link events. A fixed priority picks the one that is reported. The block also holds the character timeout counter, which advances on a tick given once per character time. The serializer, the FIFOs and the baud generator sit outside the block.

The block watches the register bus so that accesses elsewhere in the UART have their clearing effects. These accesses are reads of the line status, receive buffer, modem status and identification registers, and writes to the transmit holder. A write to the extended enable address sets the four enables of the extended events. The output `iid_rdata` always holds the current identification byte, and the bus read multiplexer returns it when the identification address is read. A clearing side effect takes place at the clock edge that ends the read cycle. The read itself therefore returns the code as it stood before the clear.

Top module: `uart_int_ident`

## Requirements
- R1: `iid_rdata[7:6]` always reads 2'b11 and `iid_rdata[5:4]` always reads 2'b00.
- R2: After reset, and whenever no cause is pending, `iid_rdata[3:0]` reads 4'b0001.
- R3: A pulse on any bit of `line_err` reports 4'b0110 from the next cycle. Only a read of LSR_ADDR clears it. A line error in the same cycle as that read leaves it pending.
- R4: A rising edge of `rx_at_trig` reports 4'b0100. A read of RBR_ADDR clears it, and so does `rx_at_trig` going low. While the level stays high, no new report follows.
- R5: The code 4'b1100 is reported after the TO_CHARS-th (default 4) `char_tick` pulse with `rx_nonempty` high and no read of RBR_ADDR. Such a read clears it and restarts the count. So does an empty FIFO.
- R6: When received-data and character-timeout causes are both pending, 4'b0100 is reported. After the first clears, 4'b1100 is reported.
- R7: A rising edge of `thr_empty` reports 4'b0010. A write to THR_ADDR (the same as RBR_ADDR) clears it, and so does a read of IIR_ADDR while 4'b0010 is the reported code.
- R8: A read of IIR_ADDR while a higher-priority code is reported leaves the holder-empty cause pending.
- R9: A pulse on any bit of `msr_delta` (bits: 0 CTS, 1 DSR, 2 RI, 3 DCD) reports 4'b0000. Only a read of MSR_ADDR clears it.
- R10: The code 4'b0011 is reported while any bit of `ext_stat` is high and its enable is set. The enables reset to 0 and are loaded from `bus_wdata` by a write to XEN_ADDR. The enable bits are: 0 receiver timeout, 1 NACK, 2 PID parity, 3 LIN break.
- R11: Priority from high to low is 0110, 0100, 1100, 0010, 0000, 0011.
- R12: A read of IIR_ADDR returns the code from before its own clearing effect. The new code appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | NEXT (4) | Write data lane for the extended enables |
| iid_rdata | output | 8 | Identification byte |
| line_err | input | NERR (4) | Overrun, parity, framing and break event pulses |
| rx_at_trig | input | 1 | Receive FIFO level is at or above its trigger |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holder empty status |
| msr_delta | input | NMS (4) | Modem line change pulses |
| ext_stat | input | NEXT (4) | Extended event status levels |

## Verification
Two kinds of event can fall in the same cycle. The first is a clearing access and a new event of the cause it clears. The bench pulses a line error in the same cycle as a line status read and expects 4'b0110 to remain. The second is an identification read and a higher-priority cause. The bench reads the identification register while the line code hides a pending holder-empty cause, and expects 4'b0010 to come back after the line status read. Each expectation goes into a scoreboard queue, and a monitor compares it with the byte on the following falling edge.

// File: rtl/uart_iid_pkg.sv
// Shared codes and pending-cause bundle for the UART identification unit.
// Assumes: codes are the 4-bit identification values presented on bits [3:0].
package uart_iid_pkg;
    typedef enum logic [3:0] {
        IID_MODEM = 4'b0000,
        IID_NONE  = 4'b0001,
        IID_THRE  = 4'b0010,
        IID_MULTI = 4'b0011,
        IID_RDA   = 4'b0100,
        IID_LINE  = 4'b0110,
        IID_CTO   = 4'b1100
    } iid_code_e;

    typedef struct packed {
        logic line;
        logic rda;
        logic cto;
        logic thre;
        logic modem;
        logic multi;
    } irq_pend_t;

    localparam logic [1:0] IID_FIFO_MODE = 2'b11;
endpackage

// File: rtl/uart_cto_timer.sv
// Character timeout detector: counts character-time ticks while the receive
// FIFO is non-empty and unread; flags a timeout at the TO_CHARS-th tick.
// Assumes: char_tick is a single-cycle pulse; rbr_rd is a decoded read strobe.
module uart_cto_timer #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_tick,
    input  logic rx_nonempty,
    input  logic rbr_rd,
    output logic cto_pend
);
    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

    logic [CW-1:0] cnt;
    logic          hit;

    // Final tick of the window while still non-empty and not being read.
    assign hit = char_tick && rx_nonempty && !rbr_rd && (cnt == LAST);

    // Tick counter: restarts on a read or an empty FIFO, saturates at TO_CHARS.
    always_ff @(posedge clk) begin
        if (!rst_n || rbr_rd || !rx_nonempty)
            cnt <= '0;
        else if (char_tick && cnt != CW'(TO_CHARS))
            cnt <= cnt + 1'b1;
    end

    // Pending flag: set on the window's last tick, cleared by a buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n || rbr_rd)
            cto_pend <= 1'b0;
        else if (hit)
            cto_pend <= 1'b1;
    end

    // R5
    cto_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cto_pend) |-> $past(char_tick && rx_nonempty && !rbr_rd));
    // R5
    cto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cto_pend) |-> $past(rbr_rd));
endmodule

// File: rtl/uart_iid_sources.sv
// Pending-cause keeper: latches line, data-available, holder-empty and modem
// causes, holds the extended enables and masks the extended status levels.
// Assumes: all strobes are decoded single-cycle pulses; thre_ack is high only
// when an identification read sees the holder-empty code reported.
module uart_iid_sources
    import uart_iid_pkg::*;
#(
    parameter int NERR = 4,
    parameter int NMS  = 4,
    parameter int NEXT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] line_err,
    input  logic            rx_at_trig,
    input  logic            thr_empty,
    input  logic [NMS-1:0]  msr_delta,
    input  logic [NEXT-1:0] ext_stat,
    input  logic            lsr_rd,
    input  logic            rbr_rd,
    input  logic            msr_rd,
    input  logic            thr_wr,
    input  logic            thre_ack,
    input  logic            en_wr,
    input  logic [NEXT-1:0] en_wdata,
    input  logic            cto_pend,
    output irq_pend_t       pend
);
    logic            trig_q;
    logic            thr_q;
    logic            line_p;
    logic            rda_p;
    logic            thre_p;
    logic            modem_p;
    logic [NEXT-1:0] ext_en;

    // Edge history of the level inputs; holder-empty starts high so reset raises nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            thr_q  <= 1'b1;
        end else begin
            trig_q <= rx_at_trig;
            thr_q  <= thr_empty;
        end
    end

    // Line status cause: a new error wins over a simultaneous status read.
    always_ff @(posedge clk) begin
        if (!rst_n)              line_p <= 1'b0;
        else if (|line_err)      line_p <= 1'b1;
        else if (lsr_rd)         line_p <= 1'b0;
    end

    // Data-available cause: armed on the trigger's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rda_p <= 1'b0;
        else if (rx_at_trig && !trig_q)      rda_p <= 1'b1;
        else if (rbr_rd || !rx_at_trig)      rda_p <= 1'b0;
    end

    // Holder-empty cause: cleared by a holder write or an acknowledging read.
    always_ff @(posedge clk) begin
        if (!rst_n || thr_wr || thre_ack)    thre_p <= 1'b0;
        else if (thr_empty && !thr_q)        thre_p <= 1'b1;
    end

    // Modem cause: a new change wins over a simultaneous status read.
    always_ff @(posedge clk) begin
        if (!rst_n)              modem_p <= 1'b0;
        else if (|msr_delta)     modem_p <= 1'b1;
        else if (msr_rd)         modem_p <= 1'b0;
    end

    // Extended event enables, all disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ext_en <= '0;
        else if (en_wr)  ext_en <= en_wdata;
    end

    // Bundle the causes for the priority encoder.
    always_comb begin
        pend.line  = line_p;
        pend.rda   = rda_p;
        pend.cto   = cto_pend;
        pend.thre  = thre_p;
        pend.modem = modem_p;
        pend.multi = |(ext_stat & ext_en);
    end

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_p) |-> $past(lsr_rd));
    // R4
    rda_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rda_p) |-> $past(rbr_rd || !rx_at_trig));
    // R7
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thre_p) |-> $past(thr_wr || thre_ack));
    // R9
    modem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modem_p) |-> $past(msr_rd));
endmodule

// File: rtl/uart_iid_prio.sv
// Fixed-priority encoder from pending causes to the identification code.
// Assumes: purely combinational; pend comes from registered state.
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  irq_pend_t pend,
    output iid_code_e code
);
    // Highest pending cause wins; data-available is checked before timeout.
    always_comb begin
        if (pend.line)       code = IID_LINE;
        else if (pend.rda)   code = IID_RDA;
        else if (pend.cto)   code = IID_CTO;
        else if (pend.thre)  code = IID_THRE;
        else if (pend.modem) code = IID_MODEM;
        else if (pend.multi) code = IID_MULTI;
        else                 code = IID_NONE;
    end
endmodule

// File: rtl/uart_int_ident.sv
// UART interrupt identification unit top: decodes bus side effects, keeps the
// pending causes and the timeout counter, and presents the identification byte.
// Assumes: bus_rd/bus_wr are single-cycle strobes; THR shares RBR's address.
module uart_int_ident
    import uart_iid_pkg::*;
#(
    parameter int AW       = 3,
    parameter int RBR_ADDR = 0,
    parameter int IIR_ADDR = 2,
    parameter int LSR_ADDR = 5,
    parameter int MSR_ADDR = 6,
    parameter int XEN_ADDR = 7,
    parameter int TO_CHARS = 4,
    parameter int NERR     = 4,
    parameter int NMS      = 4,
    parameter int NEXT     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NEXT-1:0] bus_wdata,
    output logic [7:0]      iid_rdata,
    input  logic [NERR-1:0] line_err,
    input  logic            rx_at_trig,
    input  logic            rx_nonempty,
    input  logic            char_tick,
    input  logic            thr_empty,
    input  logic [NMS-1:0]  msr_delta,
    input  logic [NEXT-1:0] ext_stat
);
    logic      rbr_rd, iid_rd, lsr_rd, msr_rd, thr_wr, en_wr, thre_ack;
    logic      cto_pend;
    irq_pend_t pend;
    iid_code_e code;

    // Address decode of the side-effect accesses.
    always_comb begin
        rbr_rd = bus_rd && (bus_addr == AW'(RBR_ADDR));
        iid_rd = bus_rd && (bus_addr == AW'(IIR_ADDR));
        lsr_rd = bus_rd && (bus_addr == AW'(LSR_ADDR));
        msr_rd = bus_rd && (bus_addr == AW'(MSR_ADDR));
        thr_wr = bus_wr && (bus_addr == AW'(RBR_ADDR));
        en_wr  = bus_wr && (bus_addr == AW'(XEN_ADDR));
    end

    // Holder-empty is acknowledged only when it is the code being read.
    assign thre_ack = iid_rd && (code == IID_THRE);

    uart_cto_timer #(.TO_CHARS(TO_CHARS)) u_cto (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick),
        .rx_nonempty(rx_nonempty), .rbr_rd(rbr_rd), .cto_pend(cto_pend)
    );

    uart_iid_sources #(.NERR(NERR), .NMS(NMS), .NEXT(NEXT)) u_src (
        .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_at_trig(rx_at_trig),
        .thr_empty(thr_empty), .msr_delta(msr_delta), .ext_stat(ext_stat),
        .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
        .thre_ack(thre_ack), .en_wr(en_wr), .en_wdata(bus_wdata),
        .cto_pend(cto_pend), .pend(pend)
    );

    uart_iid_prio u_prio (.pend(pend), .code(code));

    // Identification byte: FIFO-mode marker, zero reserved bits, current code.
    assign iid_rdata = {IID_FIFO_MODE, 2'b00, code};

    // R11
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend.line |-> iid_rdata[3:0] == 4'b0110);
    // R6
    rda_over_cto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.rda && pend.cto && !pend.line) |-> iid_rdata[3:0] == 4'b0100);
    // R12
    thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && iid_rdata[3:0] == 4'b0010 && !thr_empty) |=> !pend.thre);
    // R2
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> iid_rdata[3:0] == 4'b0001);
endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_RBR = 3'd0, A_IIR = 3'd2, A_LSR = 3'd5,
                              A_MSR = 3'd6, A_XEN = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [7:0] iid_rdata;
    logic [3:0] line_err = '0;
    logic       rx_at_trig = 1'b0, rx_nonempty = 1'b0, char_tick = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] msr_delta = '0, ext_stat = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    uart_int_ident i_uart_int_ident (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .iid_rdata(iid_rdata),
        .line_err(line_err), .rx_at_trig(rx_at_trig), .rx_nonempty(rx_nonempty),
        .char_tick(char_tick), .thr_empty(thr_empty), .msr_delta(msr_delta),
        .ext_stat(ext_stat)
    );

    // Monitor: pop one expectation per falling edge and compare.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (iid_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, iid_rdata, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Driver side: expected byte is 0xC0 | code (R1 upper bits).
    task automatic expect_code(input logic [3:0] c, input string tag);
        sb_q.push_back('{exp: {4'hC, c}, tag: tag});
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a);
        bus_rd = 1'b1; bus_addr = a; step(); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; step(); bus_wr = 1'b0;
    endtask

    task automatic ctick();
        char_tick = 1'b1; step(); char_tick = 1'b0; step();
    endtask

    task automatic line_pulse(input logic [3:0] v);
        line_err = v; step(); line_err = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        expect_code(4'b0001, "R1 R2 reset state");

        // R3 line status
        line_pulse(4'b0100);
        expect_code(4'b0110, "R3 line error reported");
        rd(A_RBR);
        expect_code(4'b0110, "R3 buffer read does not clear");
        bus_rd = 1'b1; bus_addr = A_LSR; line_err = 4'b1000; step();
        bus_rd = 1'b0; line_err = '0;
        expect_code(4'b0110, "R3 error with status read stays");
        rd(A_LSR);
        expect_code(4'b0001, "R3 status read clears");

        // R7 / R12 holder empty
        thr_empty = 1'b1; step();
        expect_code(4'b0010, "R7 holder empty reported");
        step(); bus_rd = 1'b1; bus_addr = A_IIR;
        expect_code(4'b0010, "R12 read returns pre-clear code");
        step(); bus_rd = 1'b0;
        expect_code(4'b0001, "R12 cleared from next cycle");
        step(); step();
        expect_code(4'b0001, "R7 level held does not re-arm");
        thr_empty = 1'b0; step(); thr_empty = 1'b1; step();
        expect_code(4'b0010, "R7 re-armed on rising edge");
        wr(A_RBR, 4'h0);
        expect_code(4'b0001, "R7 holder write clears");

        // R8 identification read under a higher code
        thr_empty = 1'b0; step(); thr_empty = 1'b1; step();
        line_pulse(4'b0001);
        expect_code(4'b0110, "R11 line over holder empty");
        rd(A_IIR);
        expect_code(4'b0110, "R8 line still reported");
        rd(A_LSR);
        expect_code(4'b0010, "R8 holder empty survived read");
        wr(A_RBR, 4'h0);
        expect_code(4'b0001, "R7 cleared by write");

        // R4 data available
        rx_at_trig = 1'b1; step();
        expect_code(4'b0100, "R4 trigger rise reported");
        rd(A_RBR);
        expect_code(4'b0001, "R4 buffer read clears, no re-arm");
        rx_at_trig = 1'b0; step(); rx_at_trig = 1'b1; step();
        expect_code(4'b0100, "R4 second rise reported");
        rx_at_trig = 1'b0; step();
        expect_code(4'b0001, "R4 level drop clears");

        // R5 character timeout
        rx_nonempty = 1'b1; step();
        ctick(); ctick(); ctick();
        expect_code(4'b0001, "R5 three ticks not yet");
        ctick();
        expect_code(4'b1100, "R5 fourth tick reports");
        rd(A_RBR);
        expect_code(4'b0001, "R5 buffer read clears");
        ctick(); ctick(); ctick();
        expect_code(4'b0001, "R5 count restarted after read");
        ctick();
        expect_code(4'b1100, "R5 reports again after restart");

        // R6 data available ahead of timeout
        rx_at_trig = 1'b1; step();
        expect_code(4'b0100, "R6 data available over timeout");
        rx_at_trig = 1'b0; step();
        expect_code(4'b1100, "R6 timeout shown after");
        rd(A_RBR);
        expect_code(4'b0001, "R5 cleared");
        ctick(); ctick(); rx_nonempty = 1'b0; step(); rx_nonempty = 1'b1; step();
        ctick(); ctick();
        expect_code(4'b0001, "R5 empty FIFO restarts count");
        rx_nonempty = 1'b0; step();

        // R9 modem status
        msr_delta = 4'b0100; step(); msr_delta = '0;
        expect_code(4'b0000, "R9 modem change reported");
        rd(A_IIR);
        expect_code(4'b0000, "R9 identification read leaves it");
        rd(A_MSR);
        expect_code(4'b0001, "R9 modem read clears");

        // R10 extended events
        ext_stat = 4'b0010; step();
        expect_code(4'b0001, "R10 disabled after reset");
        wr(A_XEN, 4'b0010);
        expect_code(4'b0011, "R10 enabled source reported");
        msr_delta = 4'b0001; step(); msr_delta = '0;
        expect_code(4'b0000, "R11 modem over multi-mode");
        rd(A_MSR);
        expect_code(4'b0011, "R11 multi-mode after modem");
        wr(A_XEN, 4'b1101);
        expect_code(4'b0001, "R10 masked source ignored");
        ext_stat = '0; step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule